// File: doc/BRIEF.md
# Multi-Channel Match-Based PWM Generator

This block produces up to six pulse-width-modulated outputs from one free-running up-counter and seven compare values. Every output repeats at the same rate, which a compare value sets by sending the counter back to zero. Each output can be made in one of two ways. In single-edge mode it rises at the start of each cycle and falls at its own compare value. In double-edge mode it rises at the compare value of the channel below it and falls at its own, so the pulse can sit anywhere in the cycle and can go either high or low.

Software writes new compare values into shadow copies. These copies are moved into the live compare set only at the moment the counter wraps, and only for values whose commit bit is armed. A change in the middle of a cycle therefore cannot produce a short or stray pulse. Each compare value can also raise a sticky interrupt flag, reset the counter, or halt it.

Top module: `pwm_match_gen`

## Requirements
- R1: After reset the counter reads 0, the counter is halted, all outputs are low, all interrupt flags and `irq` are clear, and every shadow and live compare value is 0.
- R2: While running, the counter rises by one on each clock. When the counter equals live compare value i and reset bit i is set, the counter reads 0 on the next clock. With only compare 0 resetting at value P, the counter runs through 0 to P, so one cycle lasts P+1 counts.
- R3: Output j (bit j-1 of `pwm_out`, j = 1..6) in single-edge mode is high while the counter is below live compare value j and low for the rest of the cycle. The value 0 therefore gives a constant low, and a value above P gives a constant high.
- R4: Output j (j = 2..6) in double-edge mode goes high when the counter reaches live compare value j-1 and goes low when it reaches live compare value j. A set value below the clear value gives a positive pulse; a set value above it gives a negative-going pulse. When the two values are equal the clear wins and the output stays low.
- R5: The mode bit for output 1 is ignored, so output 1 is always single-edge.
- R6: A write to a compare address changes only its shadow copy. Shadow i is moved into the live set only on a clock where the counter resets on a match, and only if commit bit i is set. All commit bits clear on that clock.
- R7: When the counter equals live compare value i and stop bit i is set, the counter halts at that value and the outputs hold. A later write of 1 to the run register resumes counting. A write to the run register wins over a stop in the same cycle.
- R8: When the counter matches live value i and interrupt bit i is set, flag i sets and stays set until a 1 is written to its bit in the flag-clear register. A set and a clear in the same cycle leave the flag set. `irq` is the OR of all flags.
- R9: Register map (address: content): 0 to 6 are shadow compare values 0 to 6. 8 is interrupt enables [6:0]. 9 is reset-on-match bits [6:0]. 10 is stop-on-match bits [6:0]. 11 is mode bits [5:0], where bit j-1 = 1 puts output j in double-edge mode. 12 is run (bit 0). 13 is commit bits [6:0]. 14 is flag clear, where writing 1 clears that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW | Register write data |
| pwm_out | output | NOUT | PWM outputs, bit j-1 is output j |
| irq_flags | output | NOUT+1 | Sticky match flags |
| irq | output | 1 | OR of all match flags |
| tc | output | CW | Counter value |

## Verification
The assertions check, on every cycle, the properties that hold at all times:
- a match with its reset bit set brings the counter to zero on the next clock;
- a halted counter and the outputs stay frozen;
- live compare values change only on a counter reset;
- a zero compare value keeps output 1 low across a wrap;
- flags never drop unless a clear is written.

Some behaviour only the bench scenarios can show. These are the actual pulse widths and positions over a full cycle, the positive and negative double-edge pulses, the equal-edge case, and the delay before an uncommitted compare value takes effect. The bench also covers stop and resume, and clearing the flags while interrupts are enabled. A behavioural model checks all of these against the outputs on every clock.

// File: rtl/pwm_match_gen.sv
module pwm_match_gen #(
  parameter int CW   = 16,
  parameter int NOUT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [CW-1:0]   wr_data,
  output logic [NOUT-1:0] pwm_out,
  output logic [NOUT:0]   irq_flags,
  output logic            irq,
  output logic [CW-1:0]   tc
);
  localparam int NM = NOUT + 1;
  localparam logic [3:0] A_IE = 4'd8, A_RB = 4'd9, A_SB = 4'd10, A_MODE = 4'd11,
                         A_RUN = 4'd12, A_LE = 4'd13, A_CLR = 4'd14;

  logic            run;
  logic [CW-1:0]   act [NM];
  logic [CW-1:0]   shd [NM];
  logic [CW-1:0]   nact [NM];
  logic [NM-1:0]   ie, rb, sb, le, hit, clr_mask;
  logic [NOUT-1:0] mode, pwm_nx;
  logic            rst_evt, stp_evt, moves;
  logic [CW-1:0]   tc_nx;

  always_comb
    for (int i = 0; i < NM; i++) hit[i] = run && (tc == act[i]);

  assign rst_evt  = |(hit & rb);
  assign stp_evt  = |(hit & sb);
  assign moves    = run && (rst_evt || !stp_evt);
  assign tc_nx    = rst_evt ? '0 : tc + 1'b1;
  assign clr_mask = (wr_en && wr_addr == A_CLR) ? wr_data[NM-1:0] : '0;
  assign irq      = |irq_flags;

  always_comb
    for (int i = 0; i < NM; i++) nact[i] = (rst_evt && le[i]) ? shd[i] : act[i];

  always_comb
    for (int k = 0; k < NOUT; k++) begin
      logic dbl, set_e, clr_e;
      dbl   = (k > 0) && mode[k];
      set_e = dbl ? (tc_nx == nact[k]) : rst_evt;
      clr_e = (tc_nx == nact[k+1]);
      pwm_nx[k] = clr_e ? 1'b0 : (set_e ? 1'b1 : pwm_out[k]);
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;  tc <= '0;  pwm_out <= '0;  irq_flags <= '0;
      ie <= '0;  rb <= '0;  sb <= '0;  le <= '0;  mode <= '0;
      for (int i = 0; i < NM; i++) begin
        act[i] <= '0;
        shd[i] <= '0;
      end
    end else begin
      if (moves) begin
        tc      <= tc_nx;
        pwm_out <= pwm_nx;
      end
      irq_flags <= (irq_flags & ~clr_mask) | (hit & ie);
      for (int i = 0; i < NM; i++) begin
        act[i] <= nact[i];
        if (wr_en && wr_addr == 4'(i)) shd[i] <= wr_data;
      end
      if (wr_en && wr_addr == A_LE)       le <= wr_data[NM-1:0];
      else if (rst_evt)                   le <= '0;
      if (wr_en && wr_addr == A_RUN)      run <= wr_data[0];
      else if (stp_evt)                   run <= 1'b0;
      if (wr_en && wr_addr == A_IE)       ie   <= wr_data[NM-1:0];
      if (wr_en && wr_addr == A_RB)       rb   <= wr_data[NM-1:0];
      if (wr_en && wr_addr == A_SB)       sb   <= wr_data[NM-1:0];
      if (wr_en && wr_addr == A_MODE)     mode <= wr_data[NOUT-1:0];
    end
  end

  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rst_evt) |=> (tc == '0));

  p_frozen_when_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(tc) && $stable(pwm_out)));

  p_zero_width_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (moves && rst_evt && nact[1] == '0) |=> !pwm_out[0]);

  p_flags_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(irq_flags) & ~$past(clr_mask)) & ~irq_flags) == '0));

  for (genvar g = 0; g < NM; g++) begin : g_live_chk
    p_live_only_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_evt |=> $stable(act[g]));
  end
endmodule

// File: tb/pwm_match_gen_tb_top.sv
module pwm_match_gen_tb_top;
  localparam int CW = 16;
  localparam int NOUT = 6;
  localparam int NM = NOUT + 1;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NOUT-1:0] pwm_out;
  logic [NM-1:0] irq_flags;
  logic irq;
  logic [CW-1:0] tc;

  pwm_match_gen #(.CW(CW), .NOUT(NOUT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .irq_flags(irq_flags), .irq(irq), .tc(tc));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  // behavioural reference model
  int m_run, m_tc, m_ie, m_rb, m_sb, m_le, m_mode, m_flg, m_out;
  int m_act[NM], m_shd[NM];

  always @(posedge clk) begin
    int hit, rs, st, mv, ntc, clr;
    int na[NM];
    if (!rst_n) begin
      m_run = 0; m_tc = 0; m_ie = 0; m_rb = 0; m_sb = 0; m_le = 0;
      m_mode = 0; m_flg = 0; m_out = 0;
      for (int i = 0; i < NM; i++) begin m_act[i] = 0; m_shd[i] = 0; end
    end else begin
      hit = 0;
      for (int i = 0; i < NM; i++) if (m_run != 0 && m_tc == m_act[i]) hit |= (1 << i);
      rs = ((hit & m_rb) != 0);
      st = ((hit & m_sb) != 0);
      mv = (m_run != 0) && (rs != 0 || st == 0);
      ntc = rs ? 0 : (m_tc + 1) % 65536;
      for (int i = 0; i < NM; i++) na[i] = (rs != 0 && ((m_le >> i) & 1) != 0) ? m_shd[i] : m_act[i];
      if (mv) begin
        for (int k = 0; k < NOUT; k++) begin
          bit s, c;
          s = (k > 0 && ((m_mode >> k) & 1) != 0) ? (ntc == na[k]) : (rs != 0);
          c = (ntc == na[k+1]);
          if (c) m_out &= ~(1 << k);
          else if (s) m_out |= (1 << k);
        end
        m_tc = ntc;
      end
      clr = (wr_en && wr_addr == 14) ? int'(wr_data) & 'h7F : 0;
      m_flg = (m_flg & ~clr) | (hit & m_ie);
      for (int i = 0; i < NM; i++) m_act[i] = na[i];
      if (rs) m_le = 0;
      if (st) m_run = 0;
      if (wr_en) begin
        if (wr_addr < 7) m_shd[wr_addr] = int'(wr_data);
        case (wr_addr)
          8:  m_ie = int'(wr_data) & 'h7F;
          9:  m_rb = int'(wr_data) & 'h7F;
          10: m_sb = int'(wr_data) & 'h7F;
          11: m_mode = int'(wr_data) & 'h3F;
          12: m_run = int'(wr_data) & 1;
          13: m_le = int'(wr_data) & 'h7F;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 counter vs model", int'(tc), m_tc);
      check("R3/R4 outputs vs model", int'(pwm_out), m_out);
      check("R8 flags vs model", int'(irq_flags), m_flg);
    end
  end

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic high_count(int bitn, output int cnt, output int tmax);
    cnt = 0; tmax = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pwm_out[bitn]) cnt++;
      if (int'(tc) > tmax) tmax = int'(tc);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int c, t;
    repeat (3) @(negedge clk);
    check("R1 counter at reset", int'(tc), 0);
    check("R1 outputs at reset", int'(pwm_out), 0);
    check("R1 flags at reset", int'(irq_flags), 0);
    check("R1 irq at reset", int'(irq), 0);
    rst_n = 1'b1;
    wait_cyc(2);
    check("R1 halted after reset", int'(tc), 0);

    // R9 map: period 10 counts, mixed single/double
    wr(0, 9);  wr(1, 4);  wr(2, 0);  wr(3, 12);
    wr(4, 2);  wr(5, 7);  wr(6, 3);
    wr(9, 'h01); wr(8, 'h7F); wr(11, 'h31); wr(13, 'h7F);
    wr(12, 1);
    wait_cyc(25);
    high_count(0, c, t);
    check("R2 counter peak equals period value", t, 9);
    check("R3 single width 4 (R5 mode bit ignored)", c, 4);
    high_count(1, c, t);
    check("R3 zero value constant low", c, 0);
    high_count(2, c, t);
    check("R3 value above period constant high", c, 10);
    high_count(3, c, t);
    check("R3 single width 2", c, 2);
    high_count(4, c, t);
    check("R4 positive pulse width 5", c, 5);
    high_count(5, c, t);
    check("R4 negative-going pulse high 6", c, 6);
    check("R8 irq raised", int'(irq), 1);

    // R6 shadow without commit has no effect
    wr(1, 6);
    wait_cyc(20);
    high_count(0, c, t);
    check("R6 uncommitted value ignored", c, 4);
    wr(13, 'h02);
    wait_cyc(20);
    high_count(0, c, t);
    check("R6 committed value used", c, 6);

    // R4 equal edges: clear wins
    wr(6, 7); wr(13, 'h40);
    wait_cyc(20);
    high_count(5, c, t);
    check("R4 equal edges stay low", c, 0);

    // R8 flag clear and selective enable
    wr(8, 0); wr(14, 'h7F);
    check("R8 flags cleared", int'(irq_flags), 0);
    check("R8 irq cleared", int'(irq), 0);
    wr(8, 'h02);
    wait_cyc(20);
    check("R8 only enabled flag set", int'(irq_flags), 'h02);

    // R7 stop on match
    wr(3, 5); wr(13, 'h08); wr(10, 'h08);
    wait_cyc(20);
    check("R7 counter halted at stop value", int'(tc), 5);
    c = int'(pwm_out);
    wait_cyc(5);
    check("R7 counter still halted", int'(tc), 5);
    check("R7 outputs held", int'(pwm_out), c);
    wr(10, 0); wr(12, 1);
    wait_cyc(2);
    check("R7 resumed counting", int'(tc), 7);
    wait_cyc(20);

    done = 1;
    summary();
    $finish;
  end
endmodule